// File: doc/BRIEF.md
# Multiplexed-Address Block ROM Port

This block is a 4096-word by 8-bit read-only store that sits on the bus of an 8-bit processor. The processor sends a 16-bit address over eight shared lines. It first puts the high byte on the lines under an address strobe. It then puts the low byte on the same lines for the read. The block keeps the high byte in a register. Its top four bits are compared against a build-time block number, so the store answers in exactly one 4 K window of the 64 K space. The word contents come from a fixed arithmetic formula of the word address, so no file has to be loaded.

A chip-enable input and a chip-enable output let several memories share one select chain. The chain output follows the window match and the enable input, and it does not depend on the read or chip-select pins. Two chip selects gate only the data drivers. The active level of the strobe, read, enable-in and both chip selects is set per pin by parameters. The data bus is driven only while the output-enable indication is high. At all other times it floats. The model is synchronous to a system clock. The outputs are plain pins with no handshake, and `data_oe` serves as the qualifier for the data.

Top module: `mux_rom_port`

## Requirements
- R1: While `rst_n` is low, the latched high byte clears to 0x00 and `data_oe` is 0. `data_oe` stays 0 on the first clock after release.
- R2: The high byte is captured from `ad_lines` on the rising clock edge at which the strobe is sampled inactive after being sampled active on the edge before. The value taken is the one on the lines at that edge. At every other edge the stored byte keeps its value.
- R3: The window matches only when bits [7:4] of the stored high byte equal the parameter `BLOCK_SEL`. Every other upper-nibble value leaves `en_out` and `data_oe` low.
- R4: Each of the strobe, read, enable-in, chip-select-1 and chip-select-2 pins is active at the level given by its own parameter (1 means active high, 0 means active low).
- R5: `en_out` is combinational. It is 1 exactly when the window matches and the enable-in pin is active. It ignores the read and chip-select pins.
- R6: If the read pin is inactive at a rising edge, then after that edge `data_oe` is 0 and `data_out` floats.
- R7: If either chip select is inactive at a rising edge, then after that edge `data_oe` is 0. High-byte capture and `en_out` carry on unchanged.
- R8: The data is registered. After a rising edge at which the window matches, enable-in, read and both selects are active, `data_oe` is 1 and `data_out` holds the word for the low byte that was on `ad_lines` at that edge.
- R9: The word address is {stored_high[3:0], low_byte[7:0]}. The word value is low_byte XOR ((stored_high[3:0] * SEED) mod 256), with SEED defaulting to 0x1D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_lines | input | 8 | Shared address lines: high byte, then low byte |
| addr_stb | input | 1 | High-byte address strobe, level set by `STB_HIGH` |
| rd_pin | input | 1 | Memory read, level set by `RD_HIGH` |
| en_in | input | 1 | Chain enable input, level set by `ENI_HIGH` |
| cs1 | input | 1 | Driver select 1, level set by `CS1_HIGH` |
| cs2 | input | 1 | Driver select 2, level set by `CS2_HIGH` |
| data_out | output | 8 | Read data, high impedance while not enabled |
| data_oe | output | 1 | High while `data_out` is driven |
| en_out | output | 1 | Chain enable output, high when selected |

## Verification
On every cycle, the embedded assertions check four things. The stored high byte changes only at a strobe trailing edge, and at that edge it takes the line value. An inactive read or chip select always shuts off the drivers on the next edge. The chain output is never high while enable-in is inactive. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock: the word values and which upper nibble opens the window. A second instance with the opposite level on every control pin and a different block number shows that the polarity parameters really invert each pin.

// File: rtl/mux_rom_pkg.sv
package mux_rom_pkg;
  // Normalised activity of the five control pins after polarity mapping.
  typedef struct packed {
    logic stb;
    logic rd;
    logic en;
    logic cs1;
    logic cs2;
  } ctl_act_t;
endpackage

// File: rtl/mux_rom_hi_latch.sv
module mux_rom_hi_latch #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_act,
  input  logic [LINE_W-1:0] lines,
  output logic [LINE_W-1:0] hi_q
);
  logic stb_prev;
  logic trail;

  assign trail = stb_prev & ~stb_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev <= 1'b0;
      hi_q     <= '0;
    end else begin
      stb_prev <= stb_act;
      if (trail) hi_q <= lines;
    end
  end

  // R2: capture takes the line value at the trailing edge
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_prev && !stb_act) |=> (hi_q == $past(lines)));
  // R2: no trailing edge, no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_prev && !stb_act) |=> $stable(hi_q));
endmodule

// File: rtl/mux_rom_decode.sv
module mux_rom_decode #(
  parameter int LINE_W = 8,
  parameter int BLK_W  = 4,
  parameter logic [BLK_W-1:0] BLOCK_SEL = '0
) (
  input  logic [LINE_W-1:0] hi_q,
  input  logic              en_act,
  output logic              win_hit,
  output logic              selected
);
  assign win_hit  = (hi_q[LINE_W-1 -: BLK_W] == BLOCK_SEL);
  assign selected = win_hit & en_act;
endmodule

// File: rtl/mux_rom_read_stage.sv
module mux_rom_read_stage #(
  parameter int LINE_W  = 8,
  parameter int WORD_AW = 12,
  parameter logic [LINE_W-1:0] SEED = 8'h1D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_AW-1:0] word_addr,
  input  logic               selected,
  input  logic               rd_act,
  input  logic               cs1_act,
  input  logic               cs2_act,
  output logic [LINE_W-1:0]  data_q,
  output logic               oe_q
);
  function automatic logic [LINE_W-1:0] rom_word(input logic [WORD_AW-1:0] a);
    logic [LINE_W-1:0] mix;
    mix = LINE_W'(a[WORD_AW-1:LINE_W]) * SEED;
    return a[LINE_W-1:0] ^ mix;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= rom_word(word_addr);
      oe_q   <= selected & rd_act & cs1_act & cs2_act;
    end
  end

  // R6: inactive read shuts the drivers next cycle
  assert_rd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> !oe_q);
  // R7: any inactive select shuts the drivers next cycle
  assert_cs_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs1_act || !cs2_act) |=> !oe_q);
endmodule

// File: rtl/mux_rom_port.sv
module mux_rom_port #(
  parameter int LINE_W  = 8,
  parameter int WORD_AW = 12,
  parameter logic [2*LINE_W-WORD_AW-1:0] BLOCK_SEL = '0,
  parameter logic [LINE_W-1:0] SEED = 8'h1D,
  parameter bit STB_HIGH = 1'b1,
  parameter bit RD_HIGH  = 1'b0,
  parameter bit ENI_HIGH = 1'b0,
  parameter bit CS1_HIGH = 1'b1,
  parameter bit CS2_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] ad_lines,
  input  logic              addr_stb,
  input  logic              rd_pin,
  input  logic              en_in,
  input  logic              cs1,
  input  logic              cs2,
  output logic [LINE_W-1:0] data_out,
  output logic              data_oe,
  output logic              en_out
);
  import mux_rom_pkg::*;

  localparam int BLK_W = 2*LINE_W - WORD_AW;
  localparam int HI_LO = WORD_AW - LINE_W;

  ctl_act_t            act;
  logic [LINE_W-1:0]   hi_q;
  logic [LINE_W-1:0]   data_q;
  logic [WORD_AW-1:0]  word_addr;
  logic                win_hit;
  logic                selected;
  logic                oe_q;

  assign act.stb = (addr_stb == STB_HIGH);
  assign act.rd  = (rd_pin   == RD_HIGH);
  assign act.en  = (en_in    == ENI_HIGH);
  assign act.cs1 = (cs1      == CS1_HIGH);
  assign act.cs2 = (cs2      == CS2_HIGH);

  mux_rom_hi_latch #(.LINE_W(LINE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .stb_act(act.stb), .lines(ad_lines), .hi_q(hi_q)
  );

  mux_rom_decode #(.LINE_W(LINE_W), .BLK_W(BLK_W), .BLOCK_SEL(BLOCK_SEL)) u_dec (
    .hi_q(hi_q), .en_act(act.en), .win_hit(win_hit), .selected(selected)
  );

  assign word_addr = {hi_q[HI_LO-1:0], ad_lines};

  mux_rom_read_stage #(.LINE_W(LINE_W), .WORD_AW(WORD_AW), .SEED(SEED)) u_rd (
    .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .selected(selected),
    .rd_act(act.rd), .cs1_act(act.cs1), .cs2_act(act.cs2),
    .data_q(data_q), .oe_q(oe_q)
  );

  assign data_out = oe_q ? data_q : 'z;
  assign data_oe  = oe_q;
  assign en_out   = selected;

  // R5: chain output never high without an active enable-in
  assert_chain_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_out |-> act.en);
  // R3: chain output never high outside the window
  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_out |-> win_hit);
endmodule

// File: tb/mux_rom_port_tb_top.sv
`timescale 1ns/1ps
module mux_rom_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] lines = 8'h00;
  logic l_stb = 0, l_rd = 0, l_en = 0, l_cs1 = 0, l_cs2 = 0;
  wire  [7:0] d_i, d_b;
  wire        oe_i, oe_b, eo_i, eo_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Main instance: block 5, default levels.
  mux_rom_port #(.BLOCK_SEL(4'h5)) dut_i (
    .clk(clk), .rst_n(rst_n), .ad_lines(lines), .addr_stb(l_stb), .rd_pin(~l_rd),
    .en_in(~l_en), .cs1(l_cs1), .cs2(~l_cs2),
    .data_out(d_i), .data_oe(oe_i), .en_out(eo_i));

  // R4: second instance with every level inverted, block A.
  mux_rom_port #(.BLOCK_SEL(4'hA), .STB_HIGH(1'b0), .RD_HIGH(1'b1), .ENI_HIGH(1'b1),
                 .CS1_HIGH(1'b0), .CS2_HIGH(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .ad_lines(lines), .addr_stb(~l_stb), .rd_pin(l_rd),
    .en_in(l_en), .cs1(~l_cs1), .cs2(l_cs2),
    .data_out(d_b), .data_oe(oe_b), .en_out(eo_b));

  function automatic int exp_word(int hi, int lo);
    return (lo ^ (((hi % 16) * 29) % 256)) % 256;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Behavioural reference for dut_i, advanced on every rising edge.
  int m_hi = 0, m_data = 0;
  bit m_prev = 0, m_oe = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_prev = 0; m_oe = 0; m_data = 0;
    end else begin
      m_oe   = ((m_hi / 16) == 5) && l_en && l_rd && l_cs1 && l_cs2;
      m_data = exp_word(m_hi, lines);
      if (m_prev && !l_stb) m_hi = lines;
      m_prev = l_stb;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(oe_i == m_oe, "R6/R7 model data_oe", oe_i, m_oe);
      if (m_oe) check(d_i == m_data[7:0], "R9 model data", d_i, m_data);
      check(eo_i == (((m_hi / 16) == 5) && l_en), "R5 model en_out", eo_i,
            ((m_hi / 16) == 5) && l_en);
    end
  end

  task automatic idle();
    @(negedge clk); #1;
    l_stb = 0; l_rd = 0; l_cs1 = 0; l_cs2 = 0; l_en = 0;
  endtask

  task automatic send_hi(int hi);
    @(negedge clk); #1; lines = hi[7:0]; l_stb = 1;
    @(negedge clk); #1; l_stb = 0;            // trailing edge, lines still high byte
  endtask

  task automatic read_lo(int hi, int lo, bit rd, bit c1, bit c2, bit en, string tag);
    bit ei, eb;
    @(negedge clk); #1;
    lines = lo[7:0]; l_rd = rd; l_cs1 = c1; l_cs2 = c2; l_en = en;
    @(negedge clk);
    ei = ((hi / 16) == 5)  && en && rd && c1 && c2;
    eb = ((hi / 16) == 10) && en && rd && c1 && c2;
    check(oe_i == ei, {tag, " dut_i oe"}, oe_i, ei);
    if (ei) check(d_i == exp_word(hi, lo), {tag, " R8 dut_i data"}, d_i, exp_word(hi, lo));
    check(oe_b == eb, {tag, " R4 dut_b oe"}, oe_b, eb);
    if (eb) check(d_b == exp_word(hi, lo), {tag, " R4 dut_b data"}, d_b, exp_word(hi, lo));
    check(eo_i == (((hi / 16) == 5) && en), {tag, " R5 en_out"}, eo_i, ((hi / 16) == 5) && en);
    check(eo_b == (((hi / 16) == 10) && en), {tag, " R4 dut_b en_out"}, eo_b,
          ((hi / 16) == 10) && en);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(oe_i == 0 && oe_b == 0, "R1 reset data_oe", {oe_i, oe_b}, 0);
    #1 rst_n = 1;
    @(negedge clk);
    check(oe_i == 0, "R1 first cycle after release", oe_i, 0);

    // R3: every upper nibble against both instances' windows
    for (int n = 0; n < 16; n++) begin
      send_hi(n * 16 + 3);
      read_lo(n * 16 + 3, 8'h40 + n, 1, 1, 1, 1, "R3 window");
      idle();
    end
    // R9: several low bytes and low-nibble values inside the window
    for (int k = 0; k < 6; k++) begin
      send_hi(8'h50 + k * 3);
      read_lo(8'h50 + k * 3, k * 41, 1, 1, 1, 1, "R9 content");
      read_lo(8'h50 + k * 3, 255 - k, 1, 1, 1, 1, "R8 back-to-back");
      idle();
    end
    // R6: read inactive
    send_hi(8'h5E); read_lo(8'h5E, 8'h11, 0, 1, 1, 1, "R6 no read"); idle();
    send_hi(8'hA2); read_lo(8'hA2, 8'h12, 0, 1, 1, 1, "R6 no read b"); idle();
    // R7: each select inactive; en_out still follows window and enable
    send_hi(8'h57); read_lo(8'h57, 8'h13, 1, 0, 1, 1, "R7 cs1 off"); idle();
    send_hi(8'h57); read_lo(8'h57, 8'h14, 1, 1, 0, 1, "R7 cs2 off"); idle();
    // R7: high byte captured while selects off, then read with them on
    send_hi(8'h5C); read_lo(8'h5C, 8'h15, 1, 1, 1, 1, "R7 latch during cs off");
    idle();
    // R5: enable-in inactive blocks everything
    send_hi(8'h51); read_lo(8'h51, 8'h16, 1, 1, 1, 0, "R5 en off"); idle();
    // R2: lines change with strobe idle; stored byte unchanged
    send_hi(8'h5B);
    @(negedge clk); #1; lines = 8'hA0;
    @(negedge clk); #1; lines = 8'h33;
    read_lo(8'h5B, 8'h17, 1, 1, 1, 1, "R2 hold"); idle();
    // R2: strobe held over changing lines; value at trailing edge wins
    @(negedge clk); #1; lines = 8'hA4; l_stb = 1;
    @(negedge clk); #1; lines = 8'h56;
    @(negedge clk); #1; l_stb = 0;
    read_lo(8'h56, 8'h18, 1, 1, 1, 1, "R2 last value"); idle();
    // R1: reset mid-operation clears stored byte
    send_hi(8'h59);
    @(negedge clk); #1; rst_n = 0;
    @(negedge clk); #1; rst_n = 1;
    read_lo(0, 8'h19, 1, 1, 1, 1, "R1 cleared byte"); idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule